// File: doc/BRIEF.md
# Toggle-Countdown Lag Correlator

This block keeps a running count of the clock cycles in which a 1-bit serial stream is high and the same stream, taken `lag_i` cycles earlier, is also high. It needs no delay line `lag_i` bits deep. Each change of level on the input claims a free countdown timer and loads it. The timer marks that change as lying inside the most recent `lag_i` cycles until it runs out. The delayed sample equals the current sample exactly when an even number of changes lie in that window. The block therefore only needs the parity of the live timers and whether the current cycle has a change.

The pool is sized for streams with sparse changes. When a change arrives and every timer is still busy, the result can no longer be trusted. The block then raises a sticky error flag and freezes the count until the next clear. `clear_i` starts a new measurement. All history before a clear counts as zeros. `lag_i` must be held stable between clears.

Top module: `lag_correlator`

## Requirements
- R1: After reset, and in the cycle after `clear_i` is high, `sum_o` is 0 and `ovf_o` is 0.
- R2: For `lag_i` from 1 to 2^LAG_W-1, `sum_o` rises by exactly one after each cycle where `data_i` is 1 and the sample `lag_i` cycles earlier was 1. Samples from before the last clear, or taken in a clear cycle, count as 0. In all other cycles `sum_o` is unchanged.
- R3: With `lag_i` = 0, `sum_o` rises by one after every cycle where `data_i` is 1.
- R4: A change of level is a cycle where `data_i` differs from the previous sample. The previous sample is 0 after reset or clear, so a first 1 counts as a change. When `lag_i` ≥ 2, each change holds one timer for the `lag_i`-2 following cycles.
- R5: A change with `lag_i` ≥ 2 overflows when NUM_TMR changes already fall within the `lag_i`-2 cycles before it. On overflow, `ovf_o` goes to 1 and stays 1, and `sum_o` holds its value from the cycle before, until a clear.
- R6: `sum_o` saturates at 2^SUM_W-1 and stays there.
- R7: A timer whose last held cycle is the current one can be claimed by a change in that same cycle. A change exactly `lag_i`-1 cycles after the oldest of NUM_TMR changes therefore does not overflow.
- R8: In a cycle with `clear_i` high, `data_i` is ignored. It is neither counted nor remembered as history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Start a new measurement; clears count, flag and history |
| data_i | input | 1 | Serial input sample |
| lag_i | input | LAG_W | Lag in cycles; held stable between clears |
| sum_o | output | SUM_W | Saturating coincidence count |
| ovf_o | output | 1 | Sticky pool overflow flag |

## Verification
The bench sweeps every lag of a small configuration. It drives random streams with short, medium and long run lengths and compares against a full delay-line model on every cycle. A design with the parity inverted, or with the current change left out of the parity, miscounts straight away on streams with short runs. Directed sequences fill the pool and then place a new change one cycle before and exactly on the cycle a timer expires. A design that frees timers one cycle late falsely overflows in the second case, and one that frees them early misses the first. Further tests cover a long all-ones run that checks saturation, and a clear applied while the input is high, which catches a design that keeps the clear-cycle sample as history.

// File: rtl/lagcorr_pkg.sv
package lagcorr_pkg;
  localparam int unsigned DEF_LAG_W   = 11;
  localparam int unsigned DEF_NUM_TMR = 10;
  localparam int unsigned DEF_SUM_W   = 32;
endpackage

// File: rtl/lagcorr_edge.sv
module lagcorr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic data_i,
  output logic toggle_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= 1'b0;
    else if (clear_i) prev_q <= 1'b0;
    else              prev_q <= data_i;
  end

  assign toggle_o = data_i ^ prev_q;
endmodule

// File: rtl/lagcorr_timer_pool.sv
module lagcorr_timer_pool #(
  parameter int unsigned LAG_W   = 11,
  parameter int unsigned NUM_TMR = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [LAG_W-1:0] load_val_i,
  output logic             odd_o,
  output logic             full_o
);
  logic [LAG_W-1:0]   tmr_q [NUM_TMR];
  logic [NUM_TMR-1:0] live, free, grant;

  // a timer at 1 expires after this cycle, so it may be reloaded now
  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      live[i] = (tmr_q[i] != '0);
      free[i] = (tmr_q[i] <= LAG_W'(1));
    end
    for (int i = NUM_TMR - 1; i >= 0; i--)
      if (free[i]) grant = NUM_TMR'(1) << i;
  end

  assign odd_o  = ^live;
  assign full_o = ~|free;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   tmr_q[g] <= '0;
      else if (clear_i)              tmr_q[g] <= '0;
      else if (load_i && grant[g])   tmr_q[g] <= load_val_i;
      else if (tmr_q[g] != '0)       tmr_q[g] <= tmr_q[g] - LAG_W'(1);
    end

    // R4
    countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && !(load_i && grant[g]) && tmr_q[g] != '0)
        |=> tmr_q[g] == $past(tmr_q[g]) - LAG_W'(1));
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
endmodule

// File: rtl/lagcorr_accum.sv
module lagcorr_accum #(
  parameter int unsigned SUM_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             hit_i,
  input  logic             err_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             ovf_o
);
  localparam logic [SUM_W-1:0] SumMax = '1;
  logic [SUM_W-1:0] sum_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      sum_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (err_i) ovf_q <= 1'b1;
      if (hit_i && !err_i && !ovf_q && sum_q != SumMax) sum_q <= sum_q + SUM_W'(1);
    end
  end

  assign sum_o = sum_q;
  assign ovf_o = ovf_q;

  // R1
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_q == '0 && !ovf_q));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clear_i) |=> ovf_q);
  // R5
  frozen_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clear_i) |=> $stable(sum_q));
  // R2
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (sum_q == $past(sum_q) || sum_q == $past(sum_q) + SUM_W'(1)));
  // R6
  saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q == SumMax && !clear_i) |=> sum_q == SumMax);
endmodule

// File: rtl/lag_correlator.sv
module lag_correlator
  import lagcorr_pkg::*;
#(
  parameter int unsigned LAG_W   = DEF_LAG_W,
  parameter int unsigned NUM_TMR = DEF_NUM_TMR,
  parameter int unsigned SUM_W   = DEF_SUM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             data_i,
  input  logic [LAG_W-1:0] lag_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             ovf_o
);
  logic toggle, odd, full, need_tmr, in_window, hit, err;

  lagcorr_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .data_i  (data_i),
    .toggle_o(toggle)
  );

  // lag 1: the change itself is the whole window, no timer needed
  assign need_tmr  = toggle && (lag_i > LAG_W'(1));
  assign in_window = toggle && (lag_i != '0);

  lagcorr_timer_pool #(.LAG_W(LAG_W), .NUM_TMR(NUM_TMR)) u_pool (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .load_i    (need_tmr),
    .load_val_i(lag_i - LAG_W'(1)),
    .odd_o     (odd),
    .full_o    (full)
  );

  // even change count in window: delayed sample equals current sample
  assign hit = data_i && !(odd ^ in_window);
  assign err = need_tmr && full;

  lagcorr_accum #(.SUM_W(SUM_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .hit_i  (hit),
    .err_i  (err),
    .sum_o  (sum_o),
    .ovf_o  (ovf_o)
  );

  // R5
  ovf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(toggle && lag_i > LAG_W'(1)));
  // R3
  lag_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lag_i == '0 && data_i && !clear_i && !ovf_o && sum_o != '1)
      |=> sum_o == $past(sum_o) + SUM_W'(1));
endmodule

// File: tb/lag_correlator_test.sv
module lag_correlator_test;
  localparam int LW = 6, NT = 4, SW = 10;
  localparam int SMAX = (1 << SW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, data = 1'b0;
  logic [LW-1:0] lag = '0;
  logic [SW-1:0] sum;
  logic ovf;
  int vectors = 0, miscompares = 0, lag_v = 0;
  logic [63:0] hist = '0, tg = '0;
  int rsum = 0;
  bit rovf = 0, done = 0;

  always #2.5 clk = ~clk;

  lag_correlator #(.LAG_W(LW), .NUM_TMR(NT), .SUM_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .data_i(data),
    .lag_i(lag), .sum_o(sum), .ovf_o(ovf));

  task automatic check(input string req);
    vectors++;
    if (int'(sum) != rsum || ovf != rovf) begin
      miscompares++;
      $display("FAIL %s lag=%0d: sum=%0d ovf=%0b expected sum=%0d ovf=%0b",
               req, lag_v, sum, ovf, rsum, rovf);
    end
  endtask

  task automatic step(input logic d, input logic clr, input string req);
    logic tgl, dly;
    logic [63:0] mask;
    @(negedge clk);
    data = d; clear = clr;
    @(posedge clk); #1;
    if (clr) begin
      hist = '0; tg = '0; rsum = 0; rovf = 0;
    end else begin
      tgl  = d ^ hist[0];
      dly  = (lag_v == 0) ? d : hist[lag_v-1];
      mask = (lag_v >= 3) ? ((64'd1 << (lag_v - 2)) - 64'd1) : 64'd0;
      if (tgl && lag_v >= 2 && $countones(tg & mask) >= NT) rovf = 1;
      if (!rovf && d && dly && rsum < SMAX) rsum++;
      hist = {hist[62:0], d};
      tg   = {tg[62:0], tgl};
    end
    check(req);
  endtask

  task automatic set_lag(input int l);
    @(negedge clk);
    lag_v = l; lag = LW'(l);
  endtask

  task automatic run_bits(input logic [15:0] bits, input int n, input string req);
    for (int i = 0; i < n; i++) step(bits[i], 1'b0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 vectors++;
    if (sum != '0 || ovf != 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: sum=%0d ovf=%0b expected 0 0", sum, ovf);
    end
    @(negedge clk) rst_n = 1'b1;

    // sweep every lag with three run-length styles
    for (int l = 0; l < (1 << LW); l++) begin
      for (int p = 0; p < 3; p++) begin
        int maxrun, left;
        logic v;
        maxrun = (p == 0) ? 3 : (p == 1) ? 12 : 40;
        set_lag(l);
        step(1'b0, 1'b1, "R1");
        v = 1'b0; left = 0;
        for (int c = 0; c < 150; c++) begin
          if (left == 0) begin
            v = ~v;
            left = 1 + int'($urandom_range(maxrun - 1));
          end
          left--;
          step(v, 1'b0, (l == 0) ? "R3" : "R2");
        end
      end
    end

    // pool full, change at the expiry cycle: no overflow
    set_lag(10);
    step(1'b0, 1'b1, "R1");
    run_bits(16'b0000_0010_0000_0101, 14, "R7");
    if (ovf) begin miscompares++; $display("FAIL R7 ovf=1 expected 0"); end
    vectors++;

    // pool full, change one cycle before expiry: overflow
    step(1'b0, 1'b1, "R1");
    run_bits(16'b0000_0001_0000_0101, 14, "R5");
    if (!ovf) begin miscompares++; $display("FAIL R5 ovf=0 expected 1"); end
    vectors++;
    for (int c = 0; c < 30; c++) step(c[2], 1'b0, "R5");

    // clear while high: sample not kept as history
    set_lag(1);
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, "R2");

    // saturation
    step(1'b0, 1'b1, "R1");
    for (int c = 0; c < SMAX + 20; c++) step(1'b1, 1'b0, "R6");
    if (int'(sum) != SMAX) begin
      miscompares++; $display("FAIL R6 sum=%0d expected %0d", sum, SMAX);
    end
    vectors++;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule